// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Output Timing and Partial Reset

This block is a first-in first-out buffer with independent write and read clocks. Words enter on the write clock and leave on the read clock. Pointers cross between the two domains as Gray codes through two-stage synchronizers. The full condition is decided on the write side and the empty condition on the read side.

The output behaviour is chosen when the master reset is applied. In standard mode each word must be fetched with a read strobe. In fall-through mode the oldest stored word is placed on the output by itself, and a read strobe discards it and brings up the next one. This lets several instances be chained for depth with no glue logic. The two status pins change meaning with the mode.

Three further flags are driven in both modes: half-full, almost-empty and almost-full. The almost thresholds come from an offset register block outside this one. A partial reset empties the buffer but keeps the latched mode. The flags are then recomputed from the mode and the offsets in force.

Top module: `dual_mode_fifo`

## Requirements
- R1: While `mrst_n` is low, both pointers return to the first location and the output timing mode is latched from `fwft_sel` (0 = standard, 1 = fall-through). After release the buffer holds zero words.
- R2: In standard mode, `empty_or` is 1 exactly when zero words are held, and `full_ir` is 1 exactly when DEPTH words are held.
- R3: In fall-through mode, `empty_or` is 1 exactly when a stored word is presented on `rdata`, and `full_ir` is 1 exactly when fewer than DEPTH words are held.
- R4: In standard mode, `rdata` takes the oldest word on the read-clock edge where `rd_en` is 1 and the buffer is not empty. Otherwise it holds its value. It is 0 after either reset.
- R5: In fall-through mode, the oldest word appears on `rdata` without any read strobe. A read-clock edge with `rd_en` at 1 while `empty_or` is 1 removes that word and presents the next one, if there is one.
- R6: Up to DEPTH words are stored and returned in write order. Each pointer's Gray code changes by at most one bit per clock.
- R7: Driving `prst_n` low returns both pointers to the first location and discards the contents. The latched timing mode and the offset inputs stay in force, and all flags are recomputed from them.
- R8: With n words held, `half_full` = (n > DEPTH/2), `almost_empty` = (n <= `ae_off`), and `almost_full` = (DEPTH - n <= `af_off`).
- R9: A write while full is ignored. A read while empty (standard mode) or while nothing is presented (fall-through mode) is ignored. Neither moves a pointer or changes the stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low; latches the mode |
| prst_n | input | 1 | Partial reset, active low; keeps the mode |
| fwft_sel | input | 1 | Mode select sampled during master reset |
| wr_en | input | 1 | Write request (write clock) |
| wdata | input | DW | Write data |
| rd_en | input | 1 | Read request (read clock) |
| rdata | output | DW | Read data |
| ae_off | input | AW+1 | Almost-empty threshold, in words |
| af_off | input | AW+1 | Almost-full threshold, in free words |
| empty_or | output | 1 | Empty flag (standard) or output ready (fall-through) |
| full_ir | output | 1 | Full flag (standard) or input ready (fall-through) |
| half_full | output | 1 | More than half the depth is held |
| almost_empty | output | 1 | Occupancy at or below the empty threshold |
| almost_full | output | 1 | Free space at or below the full threshold |

## Verification
The properties assume the following of the inputs:
- Each reset is held low for several edges of both clocks.
- `fwft_sel` is steady during a master reset.
- The offset inputs change only while no transfer is under way.

The bench meets these conditions in several ways:
- It holds each reset for four read clocks.
- It releases resets on read-clock falling edges, which never meet write-clock edges.
- It moves the offsets only between full fill-and-drain passes.
- It waits eight read clocks after each transfer, so the synchronized pointers settle before any flag is compared.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } fifo_mode_e;
endpackage

// File: rtl/fifo_sync2.sv
module fifo_sync2 #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
        end
    end

    assign dout = sync_q;
endmodule

// File: rtl/fifo_mem.sv
module fifo_mem #(
    parameter int DW = 36,
    parameter int AW = 6
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/fifo_wr_side.sv
module fifo_wr_side #(
    parameter int AW = 6
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW:0]   rgray_sync,
    input  logic [AW:0]   af_off,
    output logic [AW:0]   wgray,
    output logic [AW-1:0] waddr,
    output logic          we,
    output logic          full,
    output logic          half_full,
    output logic          almost_full
);
    localparam logic [AW:0] FULL_CNT = (AW+1)'(1 << AW);
    localparam logic [AW:0] HALF_CNT = (AW+1)'(1 << (AW - 1));

    typedef struct packed {
        logic [AW:0] bin;
        logic [AW:0] gray;
    } wstate_t;

    wstate_t st_d, st_q;
    logic [AW:0] rbin;
    logic [AW:0] count;

    function automatic logic [AW:0] gray_to_bin(input logic [AW:0] g);
        logic [AW:0] b;
        b[AW] = g[AW];
        for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    always_comb begin
        st_d        = st_q;
        rbin        = gray_to_bin(rgray_sync);
        count       = st_q.bin - rbin;
        full        = (count == FULL_CNT);
        we          = wr_en && !full;
        st_d.bin    = st_q.bin + (AW+1)'(we);
        st_d.gray   = st_d.bin ^ (st_d.bin >> 1);
        half_full   = (count > HALF_CNT);
        almost_full = ((FULL_CNT - count) <= af_off);
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wgray = st_q.gray;
    assign waddr = st_q.bin[AW-1:0];
endmodule

// File: rtl/fifo_rd_side.sv
module fifo_rd_side
    import fifo_pkg::*;
#(
    parameter int DW = 36,
    parameter int AW = 6
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          mrst_n,
    input  logic          fwft_sel,
    input  logic          rd_en,
    input  logic [AW:0]   wgray_sync,
    input  logic [AW:0]   ae_off,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output fifo_mode_e    mode,
    output logic          empty,
    output logic          out_valid,
    output logic [DW-1:0] rdata,
    output logic          almost_empty
);
    typedef struct packed {
        logic [AW:0]   bin;
        logic [AW:0]   gray;
        logic          ov;
        logic [DW-1:0] q;
    } rstate_t;

    rstate_t     st_d, st_q;
    fifo_mode_e  mode_q;
    logic [AW:0] wbin;
    logic [AW:0] bin_nxt;
    logic        fire;

    function automatic logic [AW:0] gray_to_bin(input logic [AW:0] g);
        logic [AW:0] b;
        b[AW] = g[AW];
        for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    // pointer step: decides which memory word is addressed this cycle
    always_comb begin
        wbin    = gray_to_bin(wgray_sync);
        empty   = (st_q.bin == wbin);
        fire    = (mode_q == MODE_FWFT) ? (rd_en && st_q.ov) : (rd_en && !empty);
        bin_nxt = st_q.bin + (AW+1)'(fire);
    end

    assign raddr = (mode_q == MODE_FWFT) ? bin_nxt[AW-1:0] : st_q.bin[AW-1:0];

    always_comb begin
        st_d      = st_q;
        st_d.bin  = bin_nxt;
        st_d.gray = bin_nxt ^ (bin_nxt >> 1);
        if (mode_q == MODE_FWFT) begin
            st_d.ov = (bin_nxt != wbin);
            if (st_d.ov) st_d.q = mem_rdata;
        end else begin
            st_d.ov = 1'b0;
            if (fire) st_d.q = mem_rdata;
        end
        almost_empty = ((wbin - st_q.bin) <= ae_off);
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // timing mode: loaded only while master reset is held
    always_ff @(posedge rclk) begin
        if (!mrst_n) mode_q <= fifo_mode_e'(fwft_sel);
    end

    assign rgray     = st_q.gray;
    assign mode      = mode_q;
    assign out_valid = st_q.ov;
    assign rdata     = st_q.q;
endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo
    import fifo_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int DW    = 36,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          fwft_sel,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    input  logic          rd_en,
    output logic [DW-1:0] rdata,
    input  logic [AW:0]   ae_off,
    input  logic [AW:0]   af_off,
    output logic          empty_or,
    output logic          full_ir,
    output logic          half_full,
    output logic          almost_empty,
    output logic          almost_full
);
    logic          rst_n;
    logic [AW:0]   wgray, rgray, wgray_sync, rgray_sync;
    logic [AW-1:0] waddr, raddr;
    logic          we, full_w, empty_r, ov;
    logic [DW-1:0] mem_rdata;
    fifo_mode_e    mode;

    assign rst_n = mrst_n & prst_n;

    fifo_mem #(.DW(DW), .AW(AW)) mem_i (
        .wclk(wclk), .we(we), .waddr(waddr), .wdata(wdata),
        .raddr(raddr), .rdata(mem_rdata)
    );

    fifo_sync2 #(.W(AW+1)) w2r_i (
        .clk(rclk), .rst_n(rst_n), .din(wgray), .dout(wgray_sync)
    );

    fifo_sync2 #(.W(AW+1)) r2w_i (
        .clk(wclk), .rst_n(rst_n), .din(rgray), .dout(rgray_sync)
    );

    fifo_wr_side #(.AW(AW)) wr_i (
        .wclk(wclk), .rst_n(rst_n), .wr_en(wr_en), .rgray_sync(rgray_sync),
        .af_off(af_off), .wgray(wgray), .waddr(waddr), .we(we),
        .full(full_w), .half_full(half_full), .almost_full(almost_full)
    );

    fifo_rd_side #(.DW(DW), .AW(AW)) rd_i (
        .rclk(rclk), .rst_n(rst_n), .mrst_n(mrst_n), .fwft_sel(fwft_sel),
        .rd_en(rd_en), .wgray_sync(wgray_sync), .ae_off(ae_off),
        .mem_rdata(mem_rdata), .raddr(raddr), .rgray(rgray), .mode(mode),
        .empty(empty_r), .out_valid(ov), .rdata(rdata),
        .almost_empty(almost_empty)
    );

    assign empty_or = (mode == MODE_FWFT) ? ov : empty_r;
    assign full_ir  = (mode == MODE_FWFT) ? !full_w : full_w;
endmodule

// File: rtl/dual_mode_fifo_chk.sv
module dual_mode_fifo_chk
    import fifo_pkg::*;
#(
    parameter int DW = 36,
    parameter int AW = 6
) (
    input logic          wclk,
    input logic          rclk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic          full_w,
    input logic          empty_r,
    input fifo_mode_e    mode,
    input logic [AW:0]   wgray,
    input logic [AW:0]   rgray,
    input logic [DW-1:0] rdata,
    input logic          empty_or
);
    // R9: a write into a full buffer leaves the write pointer alone
    a_r9_no_write_when_full: assert property (@(posedge wclk) disable iff (!rst_n)
        (full_w && wr_en) |=> $stable(wgray));

    // R9: a standard-mode read of an empty buffer leaves the read pointer alone
    a_r9_no_read_when_empty: assert property (@(posedge rclk) disable iff (!rst_n)
        (mode == MODE_STD && empty_r && rd_en) |=> $stable(rgray));

    // R6: Gray pointers move by one bit at most
    a_r6_wgray_one_bit: assert property (@(posedge wclk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);

    a_r6_rgray_one_bit: assert property (@(posedge rclk) disable iff (!rst_n)
        $countones(rgray ^ $past(rgray)) <= 1);

    // R3: output ready implies the read side sees stored data
    a_r3_ready_has_data: assert property (@(posedge rclk) disable iff (!rst_n)
        (mode == MODE_FWFT && empty_or) |-> !empty_r);

    // R5: a presented word stays until it is consumed
    a_r5_head_held: assert property (@(posedge rclk) disable iff (!rst_n)
        (mode == MODE_FWFT && empty_or && !rd_en) |=> ($stable(rdata) && empty_or));

    // R4: standard-mode output holds unless a valid read occurs
    a_r4_std_hold: assert property (@(posedge rclk) disable iff (!rst_n)
        (mode == MODE_STD && !(rd_en && !empty_r)) |=> $stable(rdata));
endmodule

bind dual_mode_fifo dual_mode_fifo_chk #(.DW(DW), .AW(AW)) chk_i (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .full_w(full_w), .empty_r(empty_r), .mode(mode), .wgray(wgray),
    .rgray(rgray), .rdata(rdata), .empty_or(empty_or)
);

// File: tb/dual_mode_fifo_tb.sv
`timescale 1ns/100ps
module dual_mode_fifo_tb_top;
    localparam int D  = 8;
    localparam int DW = 8;
    localparam int AW = 3;

    logic          wclk = 1'b0;
    logic          rclk = 1'b0;
    logic          mrst_n = 1'b0;
    logic          prst_n = 1'b1;
    logic          fwft_sel = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] rdata;
    logic [AW:0]   ae_off = 4'd2;
    logic [AW:0]   af_off = 4'd2;
    logic          empty_or, full_ir, half_full, almost_empty, almost_full;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  fwft    = 1'b0;
    bit  done    = 1'b0;

    always #2 wclk = ~wclk;
    initial begin
        #0.25;
        forever #3.5 rclk = ~rclk;
    end

    dual_mode_fifo #(.DEPTH(D), .DW(DW)) dut_i (
        .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
        .fwft_sel(fwft_sel), .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en),
        .rdata(rdata), .ae_off(ae_off), .af_off(af_off), .empty_or(empty_or),
        .full_ir(full_ir), .half_full(half_full), .almost_empty(almost_empty),
        .almost_full(almost_full)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (8) @(negedge rclk);
    endtask

    task automatic wr(input logic [DW-1:0] d);
        @(negedge wclk);
        wr_en = 1'b1;
        wdata = d;
        @(negedge wclk);
        wr_en = 1'b0;
    endtask

    task automatic rd();
        @(negedge rclk);
        rd_en = 1'b1;
        @(negedge rclk);
        rd_en = 1'b0;
    endtask

    task automatic do_reset(input bit master, input bit sel);
        @(negedge rclk);
        fwft_sel = sel;
        if (master) mrst_n = 1'b0; else prst_n = 1'b0;
        repeat (4) @(negedge rclk);
        mrst_n = 1'b1;
        prst_n = 1'b1;
        if (master) fwft = sel;
        settle();
    endtask

    // flags {empty_or, full_ir, half_full, almost_empty, almost_full} for n words
    function automatic int exp_flags(input int n);
        bit eo, fi, hf, ae, af;
        eo = fwft ? (n > 0) : (n == 0);
        fi = fwft ? (n < D) : (n == D);
        hf = n > D / 2;
        ae = n <= int'(ae_off);
        af = (D - n) <= int'(af_off);
        return {eo, fi, hf, ae, af};
    endfunction

    task automatic chk_flags(input string tag, input int n);
        chk(tag, int'({empty_or, full_ir, half_full, almost_empty, almost_full}),
            exp_flags(n));
    endtask

    initial begin
        // R1: master reset into standard mode
        do_reset(1'b1, 1'b0);
        chk_flags("R1 reset flags std", 0);
        chk("R4 rdata zero after reset", int'(rdata), 0);

        // R2 R8: fill, flags at each level
        for (int i = 1; i <= D; i++) begin
            wr(DW'(8'hA0 + i));
            settle();
            chk_flags("R2 R8 fill std", i);
        end
        // R9: write while full ignored
        wr(8'h55);
        settle();
        chk_flags("R9 write when full", D);

        // R4 R6: standard reads return data in order
        for (int i = 1; i <= D; i++) begin
            rd();
            chk("R4 R6 std read data", int'(rdata), 8'hA0 + i);
            settle();
            chk_flags("R2 R8 drain std", D - i);
        end
        // R9: read while empty ignored
        rd();
        settle();
        chk("R9 read when empty data", int'(rdata), 8'hA0 + D);
        chk_flags("R9 read when empty flags", 0);

        // R8: threshold sweep
        for (int a = 0; a < 4; a++) begin
            for (int f = 0; f < 4; f++) begin
                ae_off = AW'(a);
                af_off = AW'(f);
                settle();
                chk_flags("R8 sweep empty", 0);
                for (int i = 1; i <= D; i++) begin
                    wr(DW'(16 * a + f + i));
                    settle();
                    chk_flags("R8 sweep fill", i);
                end
                for (int i = 1; i <= D; i++) begin
                    rd();
                    chk("R6 sweep data", int'(rdata), 16 * a + f + i);
                    settle();
                    chk_flags("R8 sweep drain", D - i);
                end
            end
        end
        ae_off = 4'd1;
        af_off = 4'd3;

        // R7: partial reset in standard mode
        for (int i = 0; i < 3; i++) wr(DW'(8'h30 + i));
        settle();
        chk_flags("R7 before partial std", 3);
        do_reset(1'b0, 1'b1);
        chk_flags("R7 after partial std", 0);
        chk("R7 rdata cleared", int'(rdata), 0);
        wr(8'h77);
        settle();
        chk("R4 no read no data", int'(rdata), 0);
        rd();
        chk("R7 pointer at start", int'(rdata), 8'h77);
        settle();

        // R1 R3 R5: master reset into fall-through mode
        do_reset(1'b1, 1'b1);
        chk_flags("R1 R3 reset flags fwft", 0);
        wr(8'hB1);
        settle();
        chk_flags("R3 one word fwft", 1);
        chk("R5 head without read", int'(rdata), 8'hB1);
        for (int i = 2; i <= D; i++) begin
            wr(DW'(8'hB0 + i));
            settle();
            chk_flags("R3 R8 fill fwft", i);
            chk("R5 head held", int'(rdata), 8'hB1);
        end
        wr(8'h66);
        settle();
        chk_flags("R9 write when full fwft", D);
        for (int i = 1; i <= D; i++) begin
            chk("R5 R6 fwft data", int'(rdata), 8'hB0 + i);
            rd();
            settle();
            chk_flags("R3 R8 drain fwft", D - i);
        end
        rd();
        settle();
        chk("R9 read not ready data", int'(rdata), 8'hB0 + D);
        chk_flags("R9 read not ready flags", 0);

        // R7: partial reset keeps fall-through mode
        wr(8'hC0);
        wr(8'hC1);
        settle();
        do_reset(1'b0, 1'b0);
        chk_flags("R7 after partial fwft", 0);
        wr(8'hC5);
        settle();
        chk("R7 R5 fwft kept", int'(rdata), 8'hC5);
        chk_flags("R7 one word fwft", 1);

        // R1: master reset back to standard
        do_reset(1'b1, 1'b0);
        chk_flags("R1 back to std", 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule